// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a CPU bus, a video-chip bus and the memories on a cartridge. CPU writes at a small set of exact addresses load a group of bank registers. The block then translates CPU program-space addresses into program ROM addresses, and video pattern-space addresses into character ROM addresses. It also picks the nametable arrangement that folds the video chip's four logical nametables onto the console's 2 KiB of internal video RAM.

The CPU address window 0x6000–0x7FFF is handled in one of two ways. If work RAM is fitted, the window passes through to that RAM. If not, a single-bit latch answers in the lower 4 KiB of the window: it is written from data bit 0 and read back ORed onto the last byte seen on the bus. All address translations are combinational from the current register contents. Register writes are captured on the rising clock edge while the write strobe is high. The reset input is asynchronous, and the block releases it synchronously.

Top module: `cart_bank_mapper`

## Requirements
- R1: For CPU addresses 0x8000–0x9FFF, `prg_addr` = program bank register A × 0x2000 + `cpu_addr[12:0]`. For 0xA000–0xBFFF, program bank register B takes the place of A.
- R2: CPU addresses 0xC000–0xDFFF always map to bank 0x1E, and 0xE000–0xFFFF always map to bank 0x1F. In both cases the low 13 address bits pass through unchanged.
- R3: A write to any address 0x8000–0x8003 loads register A from `cpu_wdata[4:0]`. A write to any address 0xA000–0xA003 loads register B from `cpu_wdata[4:0]`. The new value shows on `prg_addr` from the clock edge that captures the write.
- R4: `ppu_addr[12:10]` selects one of eight 1 KiB slots, each with its own 8-bit bank. `chr_addr` = slot bank × 0x400 + `ppu_addr[9:0]`.
- R5: Each slot bank is written 4 bits at a time from `cpu_wdata[3:0]`. The nibble not being written keeps its value. Address bit 0 chooses the nibble: 0 is low and 1 is high. Address bit 1 chooses the odd slot of a pair. Page 0xB0 holds slots 0 and 1, 0xC0 holds slots 2 and 3, 0xD0 holds slots 4 and 5, and 0xE0 holds slots 6 and 7 (offsets 0–3 only).
- R6: A write to 0x9000–0x9003 loads a 2-bit arrangement code from `cpu_wdata[1:0]`. `vram_addr` = {sel, `ppu_addr[9:0]`}. The value of sel depends on the code: code 0 uses `ppu_addr[10]`, code 1 uses `ppu_addr[11]`, code 2 uses 0 and code 3 uses 1.
- R7: With no work RAM fitted (`ram_fitted`=0), a write to 0x6000–0x6FFF stores `cpu_wdata[0]` in the latch. A read in 0x6000–0x6FFF returns `open_bus` ORed with the latch in bit 0.
- R8: With no work RAM fitted, a read in 0x7000–0x7FFF returns `open_bus` unchanged. A read outside 0x6000–0x7FFF also returns `open_bus` unchanged. `ram_we` stays low whenever `ram_fitted`=0.
- R9: With work RAM fitted, a read in 0x6000–0x7FFF returns `ram_rdata`, `ram_addr` = `cpu_addr[12:0]`, and `ram_we` follows the write strobe. Writes in this mode leave the latch unchanged.
- R10: Registers decode on the full 16-bit address with an exact match. A write to any other address, for example 0x8004, 0x9004 or 0xB004, changes no register. A write to 0x7000–0x7FFF leaves the latch unchanged.
- R11: Reset clears both program bank registers, all eight slot banks, the arrangement code (which restores code 0) and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ram_fitted | input | 1 | High when work RAM is present |
| open_bus | input | 8 | Last byte seen on the CPU bus |
| ram_rdata | input | 8 | Read data from work RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_addr | output | 13 | Work RAM address |
| ram_we | output | 1 | Work RAM write enable |
| prg_addr | output | 18 | Program ROM address |
| ppu_addr | input | 14 | Video chip address |
| chr_addr | output | 18 | Character ROM address |
| vram_addr | output | 11 | Internal video RAM address |

## Verification
The checker runs on every cycle. It confirms that the fixed program windows and the 13-bit, 10-bit and nametable offset pass-throughs hold. It checks that register A and the latch take the captured write data one edge after the write, and that neither moves when no write occurs. It also checks the work-RAM read path and that `ram_we` stays low when no RAM is fitted. Only the directed scenarios show the rest: nibble merging into the slot banks, slot selection by address, each of the four arrangement codes, rejection of near-miss addresses, and the cleared state after a second reset.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    ARR_COL   = 2'd0,
    ARR_ROW   = 2'd1,
    ARR_LOW   = 2'd2,
    ARR_HIGH  = 2'd3
  } arrange_e;

  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned CPU_DW   = 8;
  localparam int unsigned PRG_OFFW = 13;
  localparam int unsigned CHR_OFFW = 10;
  localparam int unsigned PPU_AW   = 14;
endpackage

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 5,
  parameter int unsigned CHR_BANK_W = 8,
  parameter int unsigned CHR_SLOTS  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [CPU_AW-1:0]                wr_addr,
  input  logic [CPU_DW-1:0]                wr_data,
  output logic [PRG_BANK_W-1:0]            prg_bank_a,
  output logic [PRG_BANK_W-1:0]            prg_bank_b,
  output logic [CHR_SLOTS*CHR_BANK_W-1:0]  chr_banks,
  output arrange_e                         arrange
);
  localparam int unsigned NIB_W  = CHR_BANK_W / 2;
  localparam int unsigned SLOT_W = $clog2(CHR_SLOTS);

  logic [3:0] page;
  logic       low_clear;
  logic       hit_prg_a, hit_prg_b, hit_arr, hit_chr;
  logic [1:0] chr_group;
  logic [SLOT_W-1:0] chr_slot;

  always_comb begin
    page      = wr_addr[15:12];
    low_clear = (wr_addr[11:2] == 10'd0);
    hit_prg_a = wr_en && low_clear && (page == 4'h8);
    hit_prg_b = wr_en && low_clear && (page == 4'hA);
    hit_arr   = wr_en && low_clear && (page == 4'h9);
    hit_chr   = wr_en && low_clear && (page >= 4'hB) && (page <= 4'hE);
    chr_group = 2'(page - 4'hB);
    chr_slot  = SLOT_W'({chr_group, wr_addr[1]});
  end

  // program bank registers
  logic [PRG_BANK_W-1:0] prg_a_nxt, prg_b_nxt;
  logic [1:0]            arr_nxt;
  logic [1:0]            arr_q;

  always_comb begin
    prg_a_nxt = wr_data[PRG_BANK_W-1:0];
    prg_b_nxt = wr_data[PRG_BANK_W-1:0];
    arr_nxt   = wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_bank_a <= '0;
      prg_bank_b <= '0;
      arr_q      <= '0;
    end else begin
      if (hit_prg_a) prg_bank_a <= prg_a_nxt;
      if (hit_prg_b) prg_bank_b <= prg_b_nxt;
      if (hit_arr)   arr_q      <= arr_nxt;
    end
  end

  assign arrange = arrange_e'(arr_q);

  // character slot banks, written one nibble at a time
  for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_slot
    logic             en_lo, en_hi;
    logic [NIB_W-1:0] lo_q, hi_q, nib_nxt;

    always_comb begin
      en_lo   = hit_chr && (chr_slot == SLOT_W'(s)) && !wr_addr[0];
      en_hi   = hit_chr && (chr_slot == SLOT_W'(s)) &&  wr_addr[0];
      nib_nxt = wr_data[NIB_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (en_lo) lo_q <= nib_nxt;
        if (en_hi) hi_q <= nib_nxt;
      end
    end

    assign chr_banks[s*CHR_BANK_W +: CHR_BANK_W] = {hi_q, lo_q};
  end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 5
) (
  input  logic [CPU_AW-1:0]              cpu_addr,
  input  logic [PRG_BANK_W-1:0]          bank_a,
  input  logic [PRG_BANK_W-1:0]          bank_b,
  output logic [PRG_BANK_W+PRG_OFFW-1:0] prg_addr
);
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;
  localparam logic [PRG_BANK_W-1:0] NEXT_LAST = LAST_BANK - 1'b1;

  logic [PRG_BANK_W-1:0] bank_sel;

  always_comb begin
    unique case (cpu_addr[15:13])
      3'b100:  bank_sel = bank_a;
      3'b101:  bank_sel = bank_b;
      3'b110:  bank_sel = NEXT_LAST;
      3'b111:  bank_sel = LAST_BANK;
      default: bank_sel = bank_a;
    endcase
    prg_addr = {bank_sel, cpu_addr[PRG_OFFW-1:0]};
  end
endmodule

// File: rtl/cbm_ppu_map.sv
module cbm_ppu_map
  import cbm_pkg::*;
#(
  parameter int unsigned CHR_BANK_W = 8,
  parameter int unsigned CHR_SLOTS  = 8
) (
  input  logic [PPU_AW-1:0]               ppu_addr,
  input  logic [CHR_SLOTS*CHR_BANK_W-1:0] chr_banks,
  input  arrange_e                        arrange,
  output logic [CHR_BANK_W+CHR_OFFW-1:0]  chr_addr,
  output logic [CHR_OFFW:0]               vram_addr
);
  localparam int unsigned SLOT_W = $clog2(CHR_SLOTS);

  logic [SLOT_W-1:0]     slot;
  logic [CHR_BANK_W-1:0] bank;
  logic                  page_bit;

  always_comb begin
    slot = ppu_addr[CHR_OFFW +: SLOT_W];
    bank = chr_banks[slot*CHR_BANK_W +: CHR_BANK_W];
    chr_addr = {bank, ppu_addr[CHR_OFFW-1:0]};
  end

  always_comb begin
    unique case (arrange)
      ARR_COL:  page_bit = ppu_addr[10];
      ARR_ROW:  page_bit = ppu_addr[11];
      ARR_LOW:  page_bit = 1'b0;
      ARR_HIGH: page_bit = 1'b1;
      default:  page_bit = 1'b0;
    endcase
    vram_addr = {page_bit, ppu_addr[CHR_OFFW-1:0]};
  end
endmodule

// File: rtl/cbm_ram_window.sv
module cbm_ram_window
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              ram_fitted,
  input  logic [CPU_DW-1:0] open_bus,
  input  logic [CPU_DW-1:0] ram_rdata,
  output logic [CPU_DW-1:0] cpu_rdata,
  output logic [12:0]       ram_addr,
  output logic              ram_we,
  output logic              latch_q
);
  logic in_window, in_latch, latch_en, latch_nxt;

  always_comb begin
    in_window = (cpu_addr[15:13] == 3'b011);
    in_latch  = (cpu_addr[15:12] == 4'h6);
    latch_en  = cpu_we && in_latch && !ram_fitted;
    latch_nxt = cpu_wdata[0];
    ram_addr  = cpu_addr[12:0];
    ram_we    = cpu_we && in_window && ram_fitted;
    if (in_window && ram_fitted)
      cpu_rdata = ram_rdata;
    else if (in_latch)
      cpu_rdata = open_bus | {{(CPU_DW-1){1'b0}}, latch_q};
    else
      cpu_rdata = open_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_nxt;
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 5,
  parameter int unsigned CHR_BANK_W = 8,
  parameter int unsigned CHR_SLOTS  = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [15:0]                               cpu_addr,
  input  logic [7:0]                                cpu_wdata,
  input  logic                                      cpu_we,
  input  logic                                      ram_fitted,
  input  logic [7:0]                                open_bus,
  input  logic [7:0]                                ram_rdata,
  output logic [7:0]                                cpu_rdata,
  output logic [12:0]                               ram_addr,
  output logic                                      ram_we,
  output logic [PRG_BANK_W+12:0]                    prg_addr,
  input  logic [13:0]                               ppu_addr,
  output logic [CHR_BANK_W+9:0]                     chr_addr,
  output logic [10:0]                               vram_addr
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [PRG_BANK_W-1:0]           prg_bank_a, prg_bank_b;
  logic [CHR_SLOTS*CHR_BANK_W-1:0] chr_banks;
  arrange_e                        arrange;
  logic                            latch_q;

  cbm_bank_regs #(
    .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W), .CHR_SLOTS(CHR_SLOTS)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cpu_we), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .prg_bank_a(prg_bank_a), .prg_bank_b(prg_bank_b),
    .chr_banks(chr_banks), .arrange(arrange)
  );

  cbm_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .cpu_addr(cpu_addr), .bank_a(prg_bank_a), .bank_b(prg_bank_b),
    .prg_addr(prg_addr)
  );

  cbm_ppu_map #(.CHR_BANK_W(CHR_BANK_W), .CHR_SLOTS(CHR_SLOTS)) u_ppu (
    .ppu_addr(ppu_addr), .chr_banks(chr_banks), .arrange(arrange),
    .chr_addr(chr_addr), .vram_addr(vram_addr)
  );

  cbm_ram_window u_ram (
    .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ram_fitted(ram_fitted), .open_bus(open_bus),
    .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .latch_q(latch_q)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int unsigned PRG_BANK_W = 5,
  parameter int unsigned CHR_BANK_W = 8
) (
  input logic                      clk,
  input logic                      rst_sync_n,
  input logic [15:0]               cpu_addr,
  input logic [7:0]                cpu_wdata,
  input logic                      cpu_we,
  input logic                      ram_fitted,
  input logic [7:0]                ram_rdata,
  input logic [7:0]                cpu_rdata,
  input logic                      ram_we,
  input logic [PRG_BANK_W+12:0]    prg_addr,
  input logic [13:0]               ppu_addr,
  input logic [CHR_BANK_W+9:0]     chr_addr,
  input logic [10:0]               vram_addr,
  input logic [PRG_BANK_W-1:0]     prg_bank_a,
  input logic                      latch_q
);
  localparam logic [PRG_BANK_W-1:0] TOP_BANK = '1;
  localparam logic [PRG_BANK_W-1:0] TOP_LESS = TOP_BANK - 1'b1;

  assert_prg_offset_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_addr[15] |-> prg_addr[12:0] == cpu_addr[12:0]);

  assert_fixed_c_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_addr[15:13] == 3'b110) |-> prg_addr[PRG_BANK_W+12:13] == TOP_LESS);

  assert_fixed_e_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_addr[15:13] == 3'b111) |-> prg_addr[PRG_BANK_W+12:13] == TOP_BANK);

  assert_prg_load_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_we && cpu_addr[15:2] == 14'h2000) |=> prg_bank_a == $past(cpu_wdata[PRG_BANK_W-1:0]));

  assert_chr_offset_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    chr_addr[9:0] == ppu_addr[9:0]);

  assert_vram_offset_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vram_addr[9:0] == ppu_addr[9:0]);

  assert_latch_load_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ram_fitted && cpu_we && cpu_addr[15:12] == 4'h6) |=> latch_q == $past(cpu_wdata[0]));

  assert_no_ram_we_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ram_fitted |-> !ram_we);

  assert_ram_read_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_fitted && cpu_addr[15:13] == 3'b011) |-> cpu_rdata == ram_rdata);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_we |=> ($stable(prg_bank_a) && $stable(latch_q)));
endmodule

bind cart_bank_mapper cbm_checker #(
  .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .ram_fitted(ram_fitted), .ram_rdata(ram_rdata),
  .cpu_rdata(cpu_rdata), .ram_we(ram_we), .prg_addr(prg_addr),
  .ppu_addr(ppu_addr), .chr_addr(chr_addr), .vram_addr(vram_addr),
  .prg_bank_a(prg_bank_a), .latch_q(latch_q)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic        ram_fitted;
  logic [7:0]  open_bus;
  logic [7:0]  ram_rdata;
  logic [7:0]  cpu_rdata;
  logic [12:0] ram_addr;
  logic        ram_we;
  logic [17:0] prg_addr;
  logic [13:0] ppu_addr;
  logic [17:0] chr_addr;
  logic [10:0] vram_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ram_fitted(ram_fitted), .open_bus(open_bus),
    .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .prg_addr(prg_addr), .ppu_addr(ppu_addr),
    .chr_addr(chr_addr), .vram_addr(vram_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic prg_at(input logic [15:0] a, input logic [17:0] exp, input string req);
    cpu_addr = a; #1;
    check(req, 32'(prg_addr), 32'(exp));
  endtask

  task automatic chr_at(input logic [13:0] a, input logic [17:0] exp, input string req);
    ppu_addr = a; #1;
    check(req, 32'(chr_addr), 32'(exp));
  endtask

  task automatic vram_at(input logic [13:0] a, input logic [10:0] exp, input string req);
    ppu_addr = a; #1;
    check(req, 32'(vram_addr), 32'(exp));
  endtask

  task automatic rd_at(input logic [15:0] a, input logic [7:0] exp, input string req);
    cpu_addr = a; #1;
    check(req, 32'(cpu_rdata), 32'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    ram_fitted = 1'b0; open_bus = 8'h00;
    prg_at(16'h8123, 18'h00123, "R11 bank A cleared");
    prg_at(16'hA000, 18'h00000, "R11 bank B cleared");
    chr_at(14'h1FFF, 18'h003FF, "R11 slot 7 cleared");
    vram_at(14'h2400, 11'h400, "R11 code 0 after reset");
    rd_at(16'h6000, 8'h00, "R11 latch cleared");
  endtask

  task automatic t_prg();
    cpu_write(16'h8000, 8'hE5);
    prg_at(16'h9234, 18'h0B234, "R3 bank A from data[4:0]");
    prg_at(16'h8000, 18'h0A000, "R1 window 8000 uses A");
    cpu_write(16'hA003, 8'h1F);
    prg_at(16'hA010, 18'h3E010, "R1 window A000 uses B");
    prg_at(16'hC123, 18'h3C123, "R2 fixed 0x1E");
    prg_at(16'hFFFF, 18'h3FFFF, "R2 fixed 0x1F");
  endtask

  task automatic t_chr();
    cpu_write(16'hB000, 8'h3A);
    cpu_write(16'hB001, 8'hF5);
    chr_at(14'h0123, 18'h16923, "R4 slot 0 bank 0x5A");
    cpu_write(16'hB000, 8'h07);
    chr_at(14'h0123, 18'h15D23, "R5 high nibble kept");
    cpu_write(16'hE002, 8'h0C);
    cpu_write(16'hE003, 8'h0F);
    chr_at(14'h1FFF, 18'h3F3FF, "R5 slot 7 via E002/E003");
    cpu_write(16'hC002, 8'h01);
    cpu_write(16'hC003, 8'h02);
    chr_at(14'h0C05, 18'h08405, "R4 slot 3 via C002/C003");
    chr_at(14'h0123, 18'h15D23, "R5 slot 0 untouched by others");
  endtask

  task automatic t_arrange();
    vram_at(14'h2455, 11'h455, "R6 code 0 uses bit 10");
    cpu_write(16'h9001, 8'hFD);
    vram_at(14'h2455, 11'h055, "R6 code 1 uses bit 11");
    vram_at(14'h2855, 11'h455, "R6 code 1 bit 11 set");
    cpu_write(16'h9002, 8'h02);
    vram_at(14'h2C55, 11'h055, "R6 code 2 forces low");
    cpu_write(16'h9003, 8'h03);
    vram_at(14'h2055, 11'h455, "R6 code 3 forces high");
  endtask

  task automatic t_latch();
    ram_fitted = 1'b0; open_bus = 8'h40;
    rd_at(16'h6000, 8'h40, "R7 latch starts clear");
    cpu_write(16'h6FFF, 8'h81);
    rd_at(16'h6123, 8'h41, "R7 latch ORed onto open bus");
    rd_at(16'h7000, 8'h40, "R8 upper window open bus only");
    rd_at(16'h5FFF, 8'h40, "R8 outside window open bus");
    cpu_write(16'h6000, 8'hFE);
    rd_at(16'h6000, 8'h40, "R7 latch cleared by data[0]=0");
    cpu_addr = 16'h6000; cpu_we = 1'b1; #1;
    check("R8 no ram_we without RAM", 32'(ram_we), 32'd0);
    cpu_we = 1'b0;
  endtask

  task automatic t_ram();
    ram_fitted = 1'b1; ram_rdata = 8'h9C; open_bus = 8'h00;
    rd_at(16'h7ABC, 8'h9C, "R9 RAM read data");
    check("R9 RAM address", 32'(ram_addr), 32'h1ABC);
    @(negedge clk);
    cpu_addr = 16'h6010; cpu_wdata = 8'h01; cpu_we = 1'b1; #1;
    check("R9 ram_we follows strobe", 32'(ram_we), 32'd1);
    @(negedge clk);
    cpu_we = 1'b0; ram_fitted = 1'b0;
    rd_at(16'h6010, 8'h00, "R9 latch untouched by RAM write");
  endtask

  task automatic t_ignored();
    cpu_write(16'h8004, 8'h11);
    prg_at(16'h8000, 18'h0A000, "R10 write 8004 ignored");
    cpu_write(16'hB004, 8'h0F);
    chr_at(14'h0000, 18'h15C00, "R10 write B004 ignored");
    cpu_write(16'h9004, 8'h00);
    vram_at(14'h2000, 11'h400, "R10 write 9004 ignored");
    cpu_write(16'h7000, 8'h01);
    open_bus = 8'h00;
    rd_at(16'h6000, 8'h00, "R10 write 7000 leaves latch");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; ram_fitted = 1'b0;
    open_bus = '0; ram_rdata = '0; ppu_addr = '0;
    do_reset();
    t_reset_state();
    t_prg();
    t_chr();
    t_arrange();
    t_latch();
    t_ram();
    t_ignored();
    cpu_write(16'h6000, 8'h01);
    do_reset();
    t_reset_state();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule